// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps addresses of outbound requests on a local bus into the address space of a PCIe link. It holds a small set of programmable windows. Each window has a 64-bit match value, a 64-bit mask, a 64-bit remap value and a 32-bit action word. Every request address is compared against all windows at once. Only the address bits whose mask bit is 1 take part in the compare.

On a hit, the compared bits are replaced by the remap value and the other bits pass through. The action word of the winning window goes out with the result. The action word gives the transaction type and its attributes. When no window hits, or translation is switched off globally, the address passes through unchanged with a zero action word, which means memory type.

Software programs the windows through a simple write port. It writes a window's other fields first and sets the enable bit last. The request datapath and the transaction layer sit outside this block.

Top module: `obwin_xlate`

## Requirements
- R1: A synchronous active-high `rst` disables every window and clears the global enable. While reset is applied, `rsp_valid` and `rsp_hit` are 0 at the following edge. After reset every request passes through untranslated.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` 1, so back-to-back requests give back-to-back results. Its other response fields belong to that request.
- R3: A window hits when bit 0 of its match-low word (the enable) is 1 and `((req_addr ^ match) & mask) == 0`. Bit 0 of the match value is cleared before this compare.
- R4: On a hit, `rsp_addr = (remap & mask) | (req_addr & ~mask)`.
- R5: When several windows hit, the window with the lowest index wins, and `rsp_win` gives that index.
- R6: The global enable is bit 0 of the control word (field code 7, written through any window index). While it is 0 no window hits.
- R7: With no hit, `rsp_addr` equals the request address, `rsp_action` is 0 (memory type 0x0 in bits [3:0]), and both `rsp_hit` and `rsp_win` are 0.
- R8: On a hit, `rsp_action` is the whole action word of the winning window. Bits [3:0] give the type: 0x0 is memory and 0x4 is I/O. A memory window may carry an attribute in bits [23:20].
- R9: `cfg_addr` is {window index, field code}. The field codes are: 0 match low, 1 match high, 2 remap low, 3 remap high, 4 mask low, 5 mask high, 6 action, 7 control. A write at one edge applies to a request presented in the next cycle.
- R10: A window whose mask is all zero hits every address, subject to R5. It returns the address unchanged together with its action word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | {window index[5:3], field code[2:0]} |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 64 | Local-bus request address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_action | output | 32 | Action word of the winning window, or 0 |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 3 | Index of the winning window |

## Verification
Every result is registered, so it is due at the first rising edge after the request is presented. A configuration write also takes effect at its own edge, so it applies to a request in the following cycle. The bench drives requests on falling edges, one per cycle with no gaps, and compares each result on the next falling edge against an arithmetic window model. One idle falling edge after each burst checks that `rsp_valid` has dropped. The address sweeps cover both halves of the match value and the priority between overlapping windows. They also cover a disabled window, the global enable being off, a window with an all-zero mask, and a reset in the middle of a run.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  typedef enum logic [2:0] {
    FLD_MATCH_LO = 3'd0,
    FLD_MATCH_HI = 3'd1,
    FLD_REMAP_LO = 3'd2,
    FLD_REMAP_HI = 3'd3,
    FLD_MASK_LO  = 3'd4,
    FLD_MASK_HI  = 3'd5,
    FLD_ACTION   = 3'd6,
    FLD_CTRL     = 3'd7
  } fld_e;

  localparam logic [3:0] TYPE_MEM = 4'h0;
  localparam logic [3:0] TYPE_IO  = 4'h4;
endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
  import obwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int AW  = 2 * DW,
  localparam int WB  = $clog2(NWIN)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [WB-1:0]            cfg_win,
  input  fld_e                     cfg_fld,
  input  logic [DW-1:0]            cfg_wdata,
  output logic [NWIN-1:0][AW-1:0]  match_q,
  output logic [NWIN-1:0][AW-1:0]  mask_q,
  output logic [NWIN-1:0][AW-1:0]  remap_q,
  output logic [NWIN-1:0][DW-1:0]  action_q,
  output logic                     glob_en
);
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [AW-1:0] m_r, k_r, r_r;
    logic [DW-1:0] a_r;
    logic          sel;
    assign sel = cfg_we && (cfg_win == WB'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        m_r <= '0;
        k_r <= '0;
        r_r <= '0;
        a_r <= '0;
      end else if (sel) begin
        case (cfg_fld)
          FLD_MATCH_LO: m_r[DW-1:0]  <= cfg_wdata;
          FLD_MATCH_HI: m_r[AW-1:DW] <= cfg_wdata;
          FLD_REMAP_LO: r_r[DW-1:0]  <= cfg_wdata;
          FLD_REMAP_HI: r_r[AW-1:DW] <= cfg_wdata;
          FLD_MASK_LO:  k_r[DW-1:0]  <= cfg_wdata;
          FLD_MASK_HI:  k_r[AW-1:DW] <= cfg_wdata;
          FLD_ACTION:   a_r          <= cfg_wdata;
          default:      ;
        endcase
      end
    end

    assign match_q[w]  = m_r;
    assign mask_q[w]   = k_r;
    assign remap_q[w]  = r_r;
    assign action_q[w] = a_r;
  end

  always_ff @(posedge clk) begin
    if (rst) glob_en <= 1'b0;
    else if (cfg_we && cfg_fld == FLD_CTRL) glob_en <= cfg_wdata[0];
  end
endmodule

// File: rtl/obwin_match.sv
module obwin_match #(
  parameter int NWIN = 8,
  parameter int AW   = 64
) (
  input  logic [AW-1:0]            addr,
  input  logic                     glob_en,
  input  logic [NWIN-1:0][AW-1:0]  match_q,
  input  logic [NWIN-1:0][AW-1:0]  mask_q,
  input  logic [NWIN-1:0][AW-1:0]  remap_q,
  output logic [NWIN-1:0]          hit_vec,
  output logic [NWIN-1:0][AW-1:0]  xl_addr
);
  for (genvar w = 0; w < NWIN; w++) begin : g_cmp
    logic [AW-1:0] base;
    assign base       = {match_q[w][AW-1:1], 1'b0};
    assign hit_vec[w] = glob_en && match_q[w][0] &&
                        (((addr ^ base) & mask_q[w]) == '0);
    assign xl_addr[w] = (remap_q[w] & mask_q[w]) | (addr & ~mask_q[w]);
  end
endmodule

// File: rtl/obwin_pick.sv
module obwin_pick #(
  parameter int NWIN = 8,
  parameter int AW   = 64,
  parameter int DW   = 32,
  localparam int WB  = $clog2(NWIN)
) (
  input  logic [AW-1:0]            addr,
  input  logic [NWIN-1:0]          hit_vec,
  input  logic [NWIN-1:0][AW-1:0]  xl_addr,
  input  logic [NWIN-1:0][DW-1:0]  action_q,
  output logic                     any_hit,
  output logic [WB-1:0]            win_idx,
  output logic [AW-1:0]            out_addr,
  output logic [DW-1:0]            out_act
);
  always_comb begin
    any_hit  = 1'b0;
    win_idx  = '0;
    out_addr = addr;
    out_act  = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit  = 1'b1;
        win_idx  = WB'(i);
        out_addr = xl_addr[i];
        out_act  = action_q[i];
      end
    end
  end
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int AW  = 2 * DW,
  localparam int WB  = $clog2(NWIN),
  localparam int CA  = WB + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [CA-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic [DW-1:0] rsp_action,
  output logic          rsp_hit,
  output logic [WB-1:0] rsp_win
);
  logic [NWIN-1:0][AW-1:0] match_q, mask_q, remap_q, xl_addr;
  logic [NWIN-1:0][DW-1:0] action_q;
  logic [NWIN-1:0]         hit_vec;
  logic                    glob_en, any_hit;
  logic [WB-1:0]           win_idx;
  logic [AW-1:0]           out_addr;
  logic [DW-1:0]           out_act;

  obwin_regs #(.NWIN(NWIN), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we),
    .cfg_win(cfg_addr[CA-1:3]), .cfg_fld(fld_e'(cfg_addr[2:0])),
    .cfg_wdata(cfg_wdata), .match_q(match_q), .mask_q(mask_q),
    .remap_q(remap_q), .action_q(action_q), .glob_en(glob_en)
  );

  obwin_match #(.NWIN(NWIN), .AW(AW)) u_match (
    .addr(req_addr), .glob_en(glob_en), .match_q(match_q), .mask_q(mask_q),
    .remap_q(remap_q), .hit_vec(hit_vec), .xl_addr(xl_addr)
  );

  obwin_pick #(.NWIN(NWIN), .AW(AW), .DW(DW)) u_pick (
    .addr(req_addr), .hit_vec(hit_vec), .xl_addr(xl_addr), .action_q(action_q),
    .any_hit(any_hit), .win_idx(win_idx), .out_addr(out_addr), .out_act(out_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_win    <= '0;
      rsp_addr   <= '0;
      rsp_action <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= req_valid && any_hit;
      rsp_win    <= win_idx;
      rsp_addr   <= out_addr;
      rsp_action <= out_act;
    end
  end
endmodule

// File: rtl/obwin_chk.sv
module obwin_chk #(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int AW  = 2 * DW,
  localparam int WB  = $clog2(NWIN)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_addr,
  input logic [DW-1:0] rsp_action,
  input logic          rsp_hit,
  input logic          glob_en
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_hit));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r6_hit_needs_enable: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> $past(glob_en));

  a_r7_miss_passthrough: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == $past(req_addr) && rsp_action == '0));

  a_r2_hit_with_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);
endmodule

bind obwin_xlate obwin_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_action(rsp_action),
  .rsp_hit(rsp_hit), .glob_en(glob_en)
);

// File: tb/sim_obwin_xlate.sv
module sim_obwin_xlate;
  localparam int NWIN = 8;
  localparam int DW   = 32;
  localparam int AW   = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [5:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic [63:0]   req_addr = '0;
  logic          rsp_valid;
  logic [63:0]   rsp_addr;
  logic [31:0]   rsp_action;
  logic          rsp_hit;
  logic [2:0]    rsp_win;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_match [NWIN];
  logic [63:0] m_mask  [NWIN];
  logic [63:0] m_remap [NWIN];
  logic [31:0] m_act   [NWIN];
  logic        m_en;

  always #2 clk = ~clk;

  obwin_xlate #(.NWIN(NWIN), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_action(rsp_action),
    .rsp_hit(rsp_hit), .rsp_win(rsp_win)
  );

  task automatic model_clear();
    for (int i = 0; i < NWIN; i++) begin
      m_match[i] = '0; m_mask[i] = '0; m_remap[i] = '0; m_act[i] = '0;
    end
    m_en = 1'b0;
  endtask

  function automatic logic [100:0] predict(input logic [63:0] a);
    logic hit = 1'b0;
    logic [2:0] w = '0;
    logic [63:0] oa = a;
    logic [31:0] act = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (m_en && m_match[i][0] &&
          (((a ^ {m_match[i][63:1], 1'b0}) & m_mask[i]) == 64'h0)) begin
        hit = 1'b1; w = 3'(i);
        oa = (m_remap[i] & m_mask[i]) | (a & ~m_mask[i]);
        act = m_act[i];
      end
    end
    return {1'b1, hit, w, oa, act};
  endfunction

  task automatic check_rsp(input logic [63:0] a, input string tag);
    logic [100:0] exp, got;
    exp = predict(a);
    got = {rsp_valid, rsp_hit, rsp_win, rsp_addr, rsp_action};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, got, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s idle rsp_valid actual=%b expected=0", tag, rsp_valid);
    end
  endtask

  task automatic wr(input int win, input int fld, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'(win), 3'(fld)}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (fld == 7) m_en = d[0];
    else begin
      case (fld)
        0: m_match[win][31:0]  = d;
        1: m_match[win][63:32] = d;
        2: m_remap[win][31:0]  = d;
        3: m_remap[win][63:32] = d;
        4: m_mask[win][31:0]   = d;
        5: m_mask[win][63:32]  = d;
        default: m_act[win]    = d;
      endcase
    end
  endtask

  task automatic set_win(input int w, input logic [63:0] mt, input logic [63:0] mk,
                         input logic [63:0] rm, input logic [31:0] ac);
    wr(w, 1, mt[63:32]);
    wr(w, 3, rm[63:32]); wr(w, 2, rm[31:0]);
    wr(w, 5, mk[63:32]); wr(w, 4, mk[31:0]);
    wr(w, 6, ac);
    wr(w, 0, mt[31:0]);
  endtask

  // back-to-back requests, each result checked on the falling edge after its edge
  task automatic sweep(input logic [31:0] hi, input int n, input string tag);
    logic [63:0] pa = '0;
    logic pend = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pend) check_rsp(pa, tag);
      pa = {hi, (32'(i) << 24) | ((32'(i) * 32'h0001_2345) & 32'h00FF_FFFF)};
      req_valid = 1'b1; req_addr = pa; pend = 1'b1;
    end
    @(negedge clk);
    check_rsp(pa, tag);
    req_valid = 1'b0;
    @(negedge clk);
    check_idle({tag, " R2"});
  endtask

  task automatic one(input logic [63:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    check_rsp(a, tag);
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    model_clear();
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst = 1'b0;
    // R1 R7: nothing programmed, enable off -> pass through
    sweep(32'h0, 16, "R1 R7 empty");
    wr(0, 7, 32'h1);
    sweep(32'h0, 16, "R1 R6 R7 enabled-empty");

    // R3 R4 R5 R8 R9: overlapping windows
    set_win(0, 64'h0000_0000_4000_0001, {32'hFFFF_FFFF, 32'hF800_0000},
            64'h0000_0012_8000_0000, 32'h0020_0000);
    set_win(1, 64'h0000_0000_4000_0001, {32'hFFFF_FFFF, 32'hF000_0000},
            64'h0000_0003_0000_0000, 32'h0000_0004);
    set_win(3, 64'h0000_0001_0000_0001, {32'hFFFF_FFFF, 32'h8000_0000},
            64'h0000_00AB_8000_0000, 32'h0020_0000);
    sweep(32'h0, 256, "R3 R4 R5 R8 lo");
    sweep(32'h1, 256, "R3 R4 R8 hi");
    one(64'h0000_0000_4000_0000, "R3 R5 bit0 clear");
    one(64'h0000_0000_4000_0001, "R3 R4 bit0 set");
    one(64'h0000_0000_4800_0000, "R5 R8 second window");
    one(64'h0000_0002_4000_0000, "R3 R7 hi mismatch");

    // R6: global enable off
    wr(5, 7, 32'h0);
    sweep(32'h0, 96, "R6 disabled");
    wr(2, 7, 32'h1);
    one(64'h0000_0000_4000_0010, "R6 R9 re-enabled");

    // R3 R5: window 0 disabled through its enable bit
    wr(0, 0, 32'h4000_0000);
    sweep(32'h0, 96, "R3 R5 win0 off");

    // R10: all-zero mask catches every remaining address
    set_win(7, 64'h0000_0000_0000_0001, 64'h0, 64'hDEAD_BEEF_0000_0000, 32'h0000_0004);
    sweep(32'h0, 128, "R10 R5 lo");
    sweep(32'h2, 64, "R10 hi");

    // R1: reset mid-run clears windows and enable
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b1; req_addr = 64'h4000_0000;
    @(negedge clk);
    check_idle("R1 reset mid-run");
    rst = 1'b0; req_valid = 1'b0;
    model_clear();
    wr(0, 7, 32'h1);
    sweep(32'h0, 64, "R1 post-reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule